// File: doc/BRIEF.md
# Timing-Step Control Sequencer

This block is the control unit for a single-bus processor datapath. A three-bit step counter advances one state per clock, from T0 to T7. A decoder turns the count into eight mutually exclusive step lines. A combinational decoder reads the current step and the opcode, then raises the bus-gate, register-load, ALU-function and memory signals for that step. Every instruction starts with the same three fetch steps. After fetch, the counter keeps going only as far as that opcode needs, and then returns to T0.

The datapath owns the IR and the sign-extension of the immediate. The sequencer sees two things: the upper twenty bits of the IR, and the opcode field of the word that MBR holds during T2. It needs the second one because IR is only loaded at the end of T2, while the decision to stop at T2 must be made during T2. Memory steps stall on `mem_ready`.

States: `S_T0`…`S_T7`. The transitions are:
- **advance**: the count goes up by one.
- **stall**: the state holds while a memory step sees `mem_ready` low.
- **finish**: the counter returns to `S_T0` at the last step of an opcode.
- **reset**: the counter goes to `S_T0` asynchronously.

Top module: `step_sequencer`

## Requirements
- R1: `step_o` is one-hot at all times, with bit i meaning step Ti. Reset (`rst_n` low, asynchronous) forces T0 at once, even in the middle of a sequence.
- R2: The fetch steps are the same for every opcode.
  - T0 raises `pc_out`, `mar_in` and `c_in`, with `alu_op`=7 (increment by four).
  - T1 raises `mem_rd`, `c_out` and `pc_in`, plus `mbr_in_mem` while `mem_ready` is high.
  - T2 raises `mbr_out` and `ir_in`.
- R3: T1, load T6 and store T7 are memory-wait steps. While `mem_ready` is low, the step holds and no strobe that depends on the memory is raised.
- R4: IR fields are opcode `ir_hi[19:15]`, ra `[14:10]`, rb `[9:5]` and rc `[4:0]`. For add=12, sub=14, and=20 and or=22, the steps are:
  - T3: `reg_out` with rb, and `a_in`.
  - T4: `reg_out` with rc, `c_in`, and `alu_op` set to add=1, sub=2, and=3 or or=4.
  - T5: `c_out`, and `reg_in` with ra.
  - The sequence then finishes.
- R5: addi=13, andi=21 and ori=23 follow R4, except that at T4 `imm_out` drives the bus in place of the rc register. Their ALU codes are 1, 3 and 4.
- R6: For not=24 and neg=15, the steps are:
  - T3: `reg_out` with rb, `c_in`, and `alu_op` 5 or 6.
  - T4: `c_out`, and `reg_in` with ra.
  - The sequence finishes after T4.
- R7: Load=1 and store=3 share T3 to T5:
  - T3: `a_in`, with `zero_out` if rb is 0, or else `reg_out` with rb.
  - T4: `imm_out`, `c_in` and `alu_op`=1.
  - T5: `c_out` and `mar_in`.
- R8: For load, T6 raises `mem_rd` and `mbr_in_mem`, the latter only while ready. T7 raises `mbr_out` and `reg_in` with ra, and the sequence finishes.
- R9: For store, T6 raises `reg_out` with ra and `mbr_in_bus`. T7 raises `mem_wr` and finishes when `mem_ready` is high.
- R10: If the MBR opcode at T2 is not one of the listed codes, the sequence finishes at T2. The next cycle is T0.
- R11: At most one bus driver is active in any cycle. `mem_rd` and `mem_wr` are never high together. `reg_addr` is 0 and `alu_op` is 0 when they are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_hi | input | 20 | IR bits 31..12 (opcode, ra, rb, rc) |
| mbr_opc | input | 5 | Opcode field of the MBR word during T2 |
| mem_ready | input | 1 | Memory completes the current access |
| step_o | output | 8 | One-hot step lines T0..T7 |
| pc_out | output | 1 | PC drives the bus |
| c_out | output | 1 | C drives the bus |
| mbr_out | output | 1 | MBR drives the bus |
| reg_out | output | 1 | Register file drives the bus |
| imm_out | output | 1 | Sign-extended immediate drives the bus |
| zero_out | output | 1 | Constant zero drives the bus |
| mar_in | output | 1 | MAR loads from the bus |
| mbr_in_mem | output | 1 | MBR loads from memory |
| mbr_in_bus | output | 1 | MBR loads from the bus |
| ir_in | output | 1 | IR loads from the bus |
| pc_in | output | 1 | PC loads from the bus |
| a_in | output | 1 | A loads from the bus |
| c_in | output | 1 | C loads the ALU result |
| reg_in | output | 1 | Register file writes from the bus |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| alu_op | output | 3 | ALU function code |
| reg_addr | output | 5 | Register file address |

## Verification
The bench aims at the ends of sequences. A design with a wrong length for an opcode would either drop the register write or carry stray strobes into a step that belongs to the next fetch. It also targets load and store with rb equal to 0. A design that missed this case would add a register value, not zero, to the address. Long runs of `mem_ready` low test the stall. A counter that ignored the stall would latch MBR or finish a store before the memory answered. Unknown opcodes test the T2 decision, made from the MBR opcode while IR still holds the previous word. Decoding from IR at that point would run the old instruction's steps.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int OPC_W  = 5;
    localparam int REG_W  = 5;
    localparam int STEP_W = 3;
    localparam int N_STEP = 1 << STEP_W;

    localparam logic [OPC_W-1:0] OPC_LD   = 5'd1;
    localparam logic [OPC_W-1:0] OPC_ST   = 5'd3;
    localparam logic [OPC_W-1:0] OPC_ADD  = 5'd12;
    localparam logic [OPC_W-1:0] OPC_ADDI = 5'd13;
    localparam logic [OPC_W-1:0] OPC_SUB  = 5'd14;
    localparam logic [OPC_W-1:0] OPC_NEG  = 5'd15;
    localparam logic [OPC_W-1:0] OPC_AND  = 5'd20;
    localparam logic [OPC_W-1:0] OPC_ANDI = 5'd21;
    localparam logic [OPC_W-1:0] OPC_OR   = 5'd22;
    localparam logic [OPC_W-1:0] OPC_ORI  = 5'd23;
    localparam logic [OPC_W-1:0] OPC_NOT  = 5'd24;

    typedef enum logic [STEP_W-1:0] {
        S_T0, S_T1, S_T2, S_T3, S_T4, S_T5, S_T6, S_T7
    } step_e;

    typedef enum logic [2:0] {
        CL_RRR, CL_IMM, CL_UNA, CL_LD, CL_ST, CL_BAD
    } op_class_e;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0, ALU_ADD = 3'd1, ALU_SUB = 3'd2, ALU_AND = 3'd3,
        ALU_OR   = 3'd4, ALU_NOT = 3'd5, ALU_NEG = 3'd6, ALU_INC4 = 3'd7
    } alu_fn_e;

    typedef struct packed {
        logic             pc_out;
        logic             c_out;
        logic             mbr_out;
        logic             reg_out;
        logic             imm_out;
        logic             zero_out;
        logic             mar_in;
        logic             mbr_in_mem;
        logic             mbr_in_bus;
        logic             ir_in;
        logic             pc_in;
        logic             a_in;
        logic             c_in;
        logic             reg_in;
        logic             mem_rd;
        logic             mem_wr;
        alu_fn_e          alu;
        logic [REG_W-1:0] addr;
    } ctrl_t;

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR:  return CL_RRR;
            OPC_ADDI, OPC_ANDI, OPC_ORI:        return CL_IMM;
            OPC_NOT, OPC_NEG:                   return CL_UNA;
            OPC_LD:                             return CL_LD;
            OPC_ST:                             return CL_ST;
            default:                            return CL_BAD;
        endcase
    endfunction

    function automatic alu_fn_e alu_of(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD, OPC_ADDI: return ALU_ADD;
            OPC_SUB:           return ALU_SUB;
            OPC_AND, OPC_ANDI: return ALU_AND;
            OPC_OR, OPC_ORI:   return ALU_OR;
            OPC_NOT:           return ALU_NOT;
            OPC_NEG:           return ALU_NEG;
            default:           return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/step_counter.sv
module step_counter
    import stepseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  hold,
    output step_e step_q
);
    step_e step_d;

    always_comb begin
        if (clr)
            step_d = S_T0;
        else if (hold)
            step_d = step_q;
        else
            step_d = step_e'(step_q + 3'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step_q <= S_T0;
        else
            step_q <= step_d;
    end
endmodule

// File: rtl/step_decoder.sv
module step_decoder #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign onehot[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
    import stepseq_pkg::*;
(
    input  step_e            step,
    input  logic [19:0]      ir_hi,
    input  logic [OPC_W-1:0] mbr_opc,
    input  logic             mem_ready,
    output ctrl_t            ctrl,
    output logic             seq_end,
    output logic             wait_mem
);
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] ra, rb, rc;
    op_class_e        cls_ir, cls_mbr;

    assign opc     = ir_hi[19:15];
    assign ra      = ir_hi[14:10];
    assign rb      = ir_hi[9:5];
    assign rc      = ir_hi[4:0];
    assign cls_ir  = classify(opc);
    assign cls_mbr = classify(mbr_opc);

    always_comb begin
        ctrl     = '0;
        seq_end  = 1'b0;
        wait_mem = 1'b0;
        unique case (step)
            S_T0: begin
                ctrl.pc_out = 1'b1;
                ctrl.mar_in = 1'b1;
                ctrl.c_in   = 1'b1;
                ctrl.alu    = ALU_INC4;
            end
            S_T1: begin
                ctrl.mem_rd     = 1'b1;
                ctrl.mbr_in_mem = mem_ready;
                ctrl.c_out      = 1'b1;
                ctrl.pc_in      = 1'b1;
                wait_mem        = 1'b1;
            end
            S_T2: begin
                ctrl.mbr_out = 1'b1;
                ctrl.ir_in   = 1'b1;
                seq_end      = (cls_mbr == CL_BAD);
            end
            S_T3: begin
                unique case (cls_ir)
                    CL_RRR, CL_IMM: begin
                        ctrl.reg_out = 1'b1;
                        ctrl.addr    = rb;
                        ctrl.a_in    = 1'b1;
                    end
                    CL_UNA: begin
                        ctrl.reg_out = 1'b1;
                        ctrl.addr    = rb;
                        ctrl.alu     = alu_of(opc);
                        ctrl.c_in    = 1'b1;
                    end
                    CL_LD, CL_ST: begin
                        if (rb == '0) begin
                            ctrl.zero_out = 1'b1;
                        end else begin
                            ctrl.reg_out = 1'b1;
                            ctrl.addr    = rb;
                        end
                        ctrl.a_in = 1'b1;
                    end
                    default: seq_end = 1'b1;
                endcase
            end
            S_T4: begin
                unique case (cls_ir)
                    CL_RRR: begin
                        ctrl.reg_out = 1'b1;
                        ctrl.addr    = rc;
                        ctrl.alu     = alu_of(opc);
                        ctrl.c_in    = 1'b1;
                    end
                    CL_IMM: begin
                        ctrl.imm_out = 1'b1;
                        ctrl.alu     = alu_of(opc);
                        ctrl.c_in    = 1'b1;
                    end
                    CL_UNA: begin
                        ctrl.c_out  = 1'b1;
                        ctrl.reg_in = 1'b1;
                        ctrl.addr   = ra;
                        seq_end     = 1'b1;
                    end
                    CL_LD, CL_ST: begin
                        ctrl.imm_out = 1'b1;
                        ctrl.alu     = ALU_ADD;
                        ctrl.c_in    = 1'b1;
                    end
                    default: seq_end = 1'b1;
                endcase
            end
            S_T5: begin
                unique case (cls_ir)
                    CL_RRR, CL_IMM: begin
                        ctrl.c_out  = 1'b1;
                        ctrl.reg_in = 1'b1;
                        ctrl.addr   = ra;
                        seq_end     = 1'b1;
                    end
                    CL_LD, CL_ST: begin
                        ctrl.c_out  = 1'b1;
                        ctrl.mar_in = 1'b1;
                    end
                    default: seq_end = 1'b1;
                endcase
            end
            S_T6: begin
                unique case (cls_ir)
                    CL_LD: begin
                        ctrl.mem_rd     = 1'b1;
                        ctrl.mbr_in_mem = mem_ready;
                        wait_mem        = 1'b1;
                    end
                    CL_ST: begin
                        ctrl.reg_out    = 1'b1;
                        ctrl.addr       = ra;
                        ctrl.mbr_in_bus = 1'b1;
                    end
                    default: seq_end = 1'b1;
                endcase
            end
            S_T7: begin
                unique case (cls_ir)
                    CL_LD: begin
                        ctrl.mbr_out = 1'b1;
                        ctrl.reg_in  = 1'b1;
                        ctrl.addr    = ra;
                        seq_end      = 1'b1;
                    end
                    CL_ST: begin
                        ctrl.mem_wr = 1'b1;
                        wait_mem    = 1'b1;
                        seq_end     = mem_ready;
                    end
                    default: seq_end = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import stepseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] ir_hi,
    input  logic [4:0]  mbr_opc,
    input  logic        mem_ready,
    output logic [7:0]  step_o,
    output logic        pc_out,
    output logic        c_out,
    output logic        mbr_out,
    output logic        reg_out,
    output logic        imm_out,
    output logic        zero_out,
    output logic        mar_in,
    output logic        mbr_in_mem,
    output logic        mbr_in_bus,
    output logic        ir_in,
    output logic        pc_in,
    output logic        a_in,
    output logic        c_in,
    output logic        reg_in,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [2:0]  alu_op,
    output logic [4:0]  reg_addr
);
    step_e step_q;
    ctrl_t ctrl;
    logic  seq_end, wait_mem;

    step_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (seq_end),
        .hold   (wait_mem && !mem_ready),
        .step_q (step_q)
    );

    step_decoder #(.N(N_STEP)) u_dec (
        .idx    (step_q),
        .onehot (step_o)
    );

    ctrl_decode u_ctl (
        .step      (step_q),
        .ir_hi     (ir_hi),
        .mbr_opc   (mbr_opc),
        .mem_ready (mem_ready),
        .ctrl      (ctrl),
        .seq_end   (seq_end),
        .wait_mem  (wait_mem)
    );

    assign pc_out     = ctrl.pc_out;
    assign c_out      = ctrl.c_out;
    assign mbr_out    = ctrl.mbr_out;
    assign reg_out    = ctrl.reg_out;
    assign imm_out    = ctrl.imm_out;
    assign zero_out   = ctrl.zero_out;
    assign mar_in     = ctrl.mar_in;
    assign mbr_in_mem = ctrl.mbr_in_mem;
    assign mbr_in_bus = ctrl.mbr_in_bus;
    assign ir_in      = ctrl.ir_in;
    assign pc_in      = ctrl.pc_in;
    assign a_in       = ctrl.a_in;
    assign c_in       = ctrl.c_in;
    assign reg_in     = ctrl.reg_in;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign alu_op     = ctrl.alu;
    assign reg_addr   = ctrl.addr;
endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_ready,
    input logic [7:0] step_o,
    input logic       pc_out,
    input logic       c_out,
    input logic       mbr_out,
    input logic       reg_out,
    input logic       imm_out,
    input logic       zero_out,
    input logic       reg_in,
    input logic       mem_rd,
    input logic       mem_wr
);
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_o) == 1);

    p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[0] |=> step_o[1]);

    p_t2_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[2] |=> (step_o[3] || step_o[0]));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[1] && !mem_ready) |=> step_o[1]);

    p_write_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_in |=> step_o[0]);

    p_t7_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[7] && mem_ready) |=> step_o[0]);

    p_one_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_out, c_out, mbr_out, reg_out, imm_out, zero_out}) <= 1);

    p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind step_sequencer stepseq_checker chk_i (.*);

// File: tb/step_sequencer_tb_top.sv
module step_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] ir_hi = '0;
    logic [4:0]  mbr_opc = '0;
    logic        mem_ready = 1'b0;
    logic [7:0]  step_o;
    logic        pc_out, c_out, mbr_out, reg_out, imm_out, zero_out;
    logic        mar_in, mbr_in_mem, mbr_in_bus, ir_in, pc_in, a_in, c_in, reg_in;
    logic        mem_rd, mem_wr;
    logic [2:0]  alu_op;
    logic [4:0]  reg_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int stall   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    step_sequencer dut_i (.*);

    // expected-vector bit positions
    localparam int B_PC = 23, B_CO = 22, B_MO = 21, B_RO = 20, B_IO = 19, B_ZO = 18;
    localparam int B_MAR = 17, B_MBM = 16, B_MBB = 15, B_IR = 14, B_PCI = 13;
    localparam int B_A = 12, B_C = 11, B_RI = 10, B_RD = 9, B_WR = 8;

    localparam int K_RRR = 0, K_IMM = 1, K_UNA = 2, K_LD = 3, K_ST = 4, K_BAD = 5;

    function automatic int kind(input bit [4:0] op);
        case (op)
            5'd12, 5'd14, 5'd20, 5'd22: return K_RRR;
            5'd13, 5'd21, 5'd23:        return K_IMM;
            5'd24, 5'd15:               return K_UNA;
            5'd1:                       return K_LD;
            5'd3:                       return K_ST;
            default:                    return K_BAD;
        endcase
    endfunction

    function automatic bit [2:0] fn_code(input bit [4:0] op);
        case (op)
            5'd12, 5'd13: return 3'd1;
            5'd14:        return 3'd2;
            5'd20, 5'd21: return 3'd3;
            5'd22, 5'd23: return 3'd4;
            5'd24:        return 3'd5;
            5'd15:        return 3'd6;
            default:      return 3'd0;
        endcase
    endfunction

    function automatic bit is_wait(input int s, input int k);
        return (s == 1) || (s == 6 && k == K_LD) || (s == 7 && k == K_ST);
    endfunction

    function automatic bit is_last(input int s, input int k, input bit rdy);
        return (s == 2 && k == K_BAD) || (s == 4 && k == K_UNA) ||
               (s == 5 && (k == K_RRR || k == K_IMM)) || (s == 7 && k == K_LD) ||
               (s == 7 && k == K_ST && rdy);
    endfunction

    function automatic bit [23:0] exp_vec(input int s, input bit [4:0] op,
                                          input bit [19:0] w, input bit rdy);
        bit [23:0] e = '0;
        int        k = kind(op);
        bit [4:0]  ra = w[14:10], rb = w[9:5], rc = w[4:0];
        case (s)
            0: begin e[B_PC] = 1; e[B_MAR] = 1; e[B_C] = 1; e[7:5] = 3'd7; end
            1: begin e[B_RD] = 1; e[B_MBM] = rdy; e[B_CO] = 1; e[B_PCI] = 1; end
            2: begin e[B_MO] = 1; e[B_IR] = 1; end
            3: begin
                if (k == K_RRR || k == K_IMM) begin e[B_RO] = 1; e[4:0] = rb; e[B_A] = 1; end
                if (k == K_UNA) begin e[B_RO] = 1; e[4:0] = rb; e[B_C] = 1; e[7:5] = fn_code(op); end
                if (k == K_LD || k == K_ST) begin
                    e[B_A] = 1;
                    if (rb == 0) e[B_ZO] = 1; else begin e[B_RO] = 1; e[4:0] = rb; end
                end
            end
            4: begin
                if (k == K_RRR) begin e[B_RO] = 1; e[4:0] = rc; e[B_C] = 1; e[7:5] = fn_code(op); end
                if (k == K_IMM) begin e[B_IO] = 1; e[B_C] = 1; e[7:5] = fn_code(op); end
                if (k == K_UNA) begin e[B_CO] = 1; e[B_RI] = 1; e[4:0] = ra; end
                if (k == K_LD || k == K_ST) begin e[B_IO] = 1; e[B_C] = 1; e[7:5] = 3'd1; end
            end
            5: begin
                if (k == K_RRR || k == K_IMM) begin e[B_CO] = 1; e[B_RI] = 1; e[4:0] = ra; end
                if (k == K_LD || k == K_ST) begin e[B_CO] = 1; e[B_MAR] = 1; end
            end
            6: begin
                if (k == K_LD) begin e[B_RD] = 1; e[B_MBM] = rdy; end
                if (k == K_ST) begin e[B_RO] = 1; e[4:0] = ra; e[B_MBB] = 1; end
            end
            default: begin
                if (k == K_LD) begin e[B_MO] = 1; e[B_RI] = 1; e[4:0] = ra; end
                if (k == K_ST) e[B_WR] = 1;
            end
        endcase
        return e;
    endfunction

    function automatic string tag_of(input int s, input int k, input bit rdy);
        if (is_wait(s, k) && !rdy) return "R3";
        if (s == 2 && k == K_BAD)  return "R10";
        if (s <= 2)                return "R2";
        case (k)
            K_RRR:   return "R4";
            K_IMM:   return "R5";
            K_UNA:   return "R6";
            K_LD:    return (s <= 5) ? "R7" : "R8";
            default: return (s <= 5) ? "R7" : "R9";
        endcase
    endfunction

    function automatic bit [23:0] act_vec();
        return {pc_out, c_out, mbr_out, reg_out, imm_out, zero_out, mar_in, mbr_in_mem,
                mbr_in_bus, ir_in, pc_in, a_in, c_in, reg_in, mem_rd, mem_wr, alu_op, reg_addr};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Runs one instruction from T0; abort_at >= 0 applies reset at that step.
    task automatic run_instr(input bit [4:0] op, input bit [4:0] ra, input bit [4:0] rb,
                             input bit [4:0] rc, input int abort_at);
        bit [19:0] w = {op, ra, rb, rc};
        int        s = 0;
        int        k = kind(op);
        bit        fin = 0;
        mbr_opc = op;
        while (!fin) begin
            bit rdy;
            if (stall > 0) begin rdy = 0; stall--; end
            else rdy = ($urandom % 3) != 0;
            mem_ready = rdy;
            #1;
            if (s == abort_at) begin
                rst_n = 1'b0;
                #1;
                check(step_o == 8'h01, "R1", "async reset mid-sequence", step_o, 8'h01);
                @(negedge clk);
                rst_n = 1'b1;
                return;
            end
            check(step_o == (8'h01 << s), "R1", "one-hot step", step_o, 8'h01 << s);
            check(act_vec() == exp_vec(s, op, w, rdy), tag_of(s, k, rdy),
                  $sformatf("controls op=%0d T%0d", op, s), act_vec(), exp_vec(s, op, w, rdy));
            if (is_last(s, k, rdy)) fin = 1;
            else if (!(is_wait(s, k) && !rdy)) s++;
            @(negedge clk);
            if (s == 3 && !fin) ir_hi = w;
        end
        #1;
        check(step_o == 8'h01, tag_of(s, k, 1'b1), "finish returns to T0", step_o, 8'h01);
    endtask

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit [4:0] ops [14] = '{5'd1, 5'd3, 5'd12, 5'd13, 5'd14, 5'd15, 5'd20,
                              5'd21, 5'd22, 5'd23, 5'd24, 5'd0, 5'd31, 5'd7};
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        #1;
        check(step_o == 8'h01, "R1", "reset state", step_o, 8'h01);
        check(act_vec() == exp_vec(0, 5'd0, 20'd0, 1'b0), "R2", "reset T0 controls",
              act_vec(), exp_vec(0, 5'd0, 20'd0, 1'b0));
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        run_instr(5'd1, 5'd3, 5'd0, 5'd0, -1);   // R7 load with rb = 0
        run_instr(5'd3, 5'd9, 5'd0, 5'd0, -1);   // R7 store with rb = 0
        stall = 5;
        run_instr(5'd1, 5'd4, 5'd6, 5'd0, -1);   // R3 long stall in fetch
        run_instr(5'd3, 5'd2, 5'd5, 5'd0, -1);
        run_instr(5'd0, 5'd1, 5'd1, 5'd1, -1);   // R10 unknown opcode
        run_instr(5'd12, 5'd1, 5'd2, 5'd3, 4);   // R1 reset mid-sequence
        run_instr(5'd24, 5'd7, 5'd8, 5'd0, -1);  // R6

        for (int i = 0; i < 300; i++) begin
            if ($urandom % 10 == 0) stall = 1 + $urandom % 4;
            run_instr(ops[$urandom % 14], 5'($urandom), 5'($urandom % 4 == 0 ? 0 : $urandom),
                      5'($urandom), -1);
        end
        summary();
    end
endmodule